// File: doc/BRIEF.md
# Selectable LRU Victim Selector

This block holds the replacement history for every set of a set-associative cache and names the way that a new line should overwrite. It keeps two histories side by side for each set: an exact age ordering of the ways, and a single "recently used" bit per way. A runtime select input chooses which history decides the victim, so the policy can be changed without losing state.

The cache controller drives the set index and a way number. It pulses the access strobe on a hit or fill and the invalidate strobe when a line is dropped. To get a victim, it raises the victim request together with the set's valid bits. An invalid way always wins over the policy, and the block reports whether the chosen way was free. Tag matching and data storage sit outside the block.

Top module: `lru_victim_sel`

## Requirements
- R1: With policySel = 0 and every way of the set valid, victimWay is the way with the largest age, which is the least recently accessed one.
- R2: With policySel = 1 and every way of the set valid, victimWay is the lowest-numbered way whose use bit is 0, or way 0 if no bit is 0.
- R3: When victimReq is 1 and some bit of validBits is 0, victimWay is the lowest-numbered invalid way and victimFree is 1, for either policy. With all ways valid, victimFree is 0.
- R4: When victimReq is 0, victimWay and victimFree are both 0.
- R5: After reset, every set holds ages equal to the way index (way 0 youngest, the highest way oldest) and all use bits are 0.
- R6: An access to a way gives it age 0. Every way of that set whose age was below the accessed way's old age grows one older.
- R7: An access sets the way's use bit. If that would make all bits of the set 1, every other bit of the set is cleared instead.
- R8: An invalidate of a way gives it the largest age and clears its use bit. Every way whose age was above its old age becomes one younger.
- R9: When accEn and invEn are both 1 in the same cycle, only the invalidate takes effect.
- R10: Both histories are updated on every access and invalidate, whatever policySel is, so a change of policy takes effect in the next request with full history.
- R11: Updates change only the set named by setIdx. Other sets keep their state.
- R12: Raising victimReq does not change any replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policySel | input | 1 | 0: exact age ordering, 1: one use bit per way |
| setIdx | input | SET_W | Set being accessed, invalidated or queried |
| accWay | input | WAY_W | Way that is accessed or invalidated |
| accEn | input | 1 | Access strobe (hit or fill) |
| invEn | input | 1 | Invalidate strobe |
| validBits | input | NUM_WAYS | Valid bit of each way of the queried set |
| victimReq | input | 1 | Victim request |
| victimWay | output | WAY_W | Chosen way |
| victimFree | output | 1 | Chosen way was invalid |

## Verification
The bench builds the block with 4 sets and 8 ways. At 8 ways the age field has its full 3-bit span, and the use bits can reach the all-ones case that clears the rest of the set. With only 4 sets, random traffic returns to the same set often, so long histories build up. The untouched sets can still be probed to show that updates stay within the addressed set.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Strobes from control to datapath: one update kind per cycle at most.
  typedef struct packed {
    logic touch;  // make the way most recent
    logic drop;   // make the way the preferred victim
  } lruStrobe_t;
endpackage

// File: rtl/lru_first_one.sv
module lru_first_one #(
  parameter int N = 8,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);
  // Lowest index with req set; 0 when none is set.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/lru_ctrl.sv
module lru_ctrl
  import lru_pkg::*;
(
  input  logic       accEn,
  input  logic       invEn,
  output lruStrobe_t strobe
);
  // Invalidate has priority over an access in the same cycle.
  always_comb begin
    strobe.drop  = invEn;
    strobe.touch = accEn & ~invEn;
  end
endmodule

// File: rtl/lru_datapath.sv
module lru_datapath
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  lruStrobe_t          strobe,
  input  logic [SET_W-1:0]    setIdx,
  input  logic [WAY_W-1:0]    accWay,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic                policySel,
  input  logic                victimReq,
  output logic [WAY_W-1:0]    victimWay,
  output logic                victimFree
);
  localparam logic [WAY_W-1:0] MAX_AGE = WAY_W'(NUM_WAYS - 1);

  logic [NUM_WAYS-1:0][WAY_W-1:0] ageMem [NUM_SETS];
  logic [NUM_WAYS-1:0]            bitMem [NUM_SETS];

  logic [NUM_WAYS-1:0][WAY_W-1:0] curAge, nextAge;
  logic [WAY_W-1:0]               pivotAge;
  logic [NUM_WAYS-1:0]            curBits, nextBits, touchedBits, hitMask;
  logic [NUM_WAYS-1:0]            oldMask;
  logic [WAY_W-1:0]               freeWay, lruWay, bitWay;
  logic                           anyFree;

  assign curAge      = ageMem[setIdx];
  assign curBits     = bitMem[setIdx];
  assign pivotAge    = curAge[accWay];
  assign hitMask     = NUM_WAYS'(1) << accWay;
  assign touchedBits = curBits | hitMask;

  // Per-way age lane: drop ages the target fully, touch rejuvenates it.
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_lane
    assign nextAge[w] =
        strobe.drop  ? (hitMask[w] ? MAX_AGE :
                        (curAge[w] > pivotAge) ? curAge[w] - 1'b1 : curAge[w]) :
        strobe.touch ? (hitMask[w] ? '0 :
                        (curAge[w] < pivotAge) ? curAge[w] + 1'b1 : curAge[w]) :
        curAge[w];
    assign oldMask[w] = (curAge[w] == MAX_AGE);
  end

  always_comb begin
    nextBits = curBits;
    if (strobe.drop)       nextBits = curBits & ~hitMask;
    else if (strobe.touch) nextBits = (&touchedBits) ? hitMask : touchedBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) ageMem[s][w] <= WAY_W'(w);
        bitMem[s] <= '0;
      end
    end else if (strobe.touch || strobe.drop) begin
      ageMem[setIdx] <= nextAge;
      bitMem[setIdx] <= nextBits;
    end
  end

  lru_first_one #(.N(NUM_WAYS)) u_freePick (.req(~validBits), .idx(freeWay));
  lru_first_one #(.N(NUM_WAYS)) u_agePick  (.req(oldMask),    .idx(lruWay));
  lru_first_one #(.N(NUM_WAYS)) u_bitPick  (.req(~curBits),   .idx(bitWay));

  assign anyFree = ~&validBits;

  always_comb begin
    victimWay  = '0;
    victimFree = 1'b0;
    if (victimReq) begin
      if (anyFree) begin
        victimWay  = freeWay;
        victimFree = 1'b1;
      end else begin
        victimWay  = policySel ? bitWay : lruWay;
      end
    end
  end
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
  import lru_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                policySel,
  input  logic [SET_W-1:0]    setIdx,
  input  logic [WAY_W-1:0]    accWay,
  input  logic                accEn,
  input  logic                invEn,
  input  logic [NUM_WAYS-1:0] validBits,
  input  logic                victimReq,
  output logic [WAY_W-1:0]    victimWay,
  output logic                victimFree
);
  lruStrobe_t strobe;

  lru_ctrl u_ctrl (
    .accEn (accEn),
    .invEn (invEn),
    .strobe(strobe)
  );

  lru_datapath #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .setIdx    (setIdx),
    .accWay    (accWay),
    .validBits (validBits),
    .policySel (policySel),
    .victimReq (victimReq),
    .victimWay (victimWay),
    .victimFree(victimFree)
  );
endmodule

// File: rtl/lru_victim_sel_chk.sv
module lru_victim_sel_chk #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 8,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                policySel,
  input logic [SET_W-1:0]    setIdx,
  input logic [WAY_W-1:0]    accWay,
  input logic                accEn,
  input logic                invEn,
  input logic [NUM_WAYS-1:0] validBits,
  input logic                victimReq,
  input logic [WAY_W-1:0]    victimWay,
  input logic                victimFree
);
  assert_free_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (victimReq && !(&validBits)) |-> (victimFree && !validBits[victimWay] &&
      (((~validBits) & ((NUM_WAYS'(1) << victimWay) - 1'b1)) == '0)));

  assert_full_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (victimReq && (&validBits)) |-> !victimFree);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !victimReq |-> (victimWay == '0 && !victimFree));

  // R6 and R7: a way just accessed is never the next victim of a full set.
  assert_touch_not_victim_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !invEn) |=>
      (!(victimReq && (&validBits) && (NUM_WAYS > 1) && setIdx == $past(setIdx))
       || victimWay != $past(accWay)));

  assert_drop_oldest_R8: assert property (@(posedge clk) disable iff (!rstN)
    invEn |=>
      (!(victimReq && (&validBits) && !policySel && setIdx == $past(setIdx))
       || victimWay == $past(accWay)));
endmodule

bind lru_victim_sel lru_victim_sel_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rstN(rstN), .policySel(policySel), .setIdx(setIdx), .accWay(accWay),
  .accEn(accEn), .invEn(invEn), .validBits(validBits), .victimReq(victimReq),
  .victimWay(victimWay), .victimFree(victimFree)
);

// File: tb/lru_victim_sel_bench.sv
module lru_victim_sel_bench;
  localparam int NS = 4;
  localparam int NW = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       policySel = 1'b0;
  logic [1:0] setIdx = '0;
  logic [2:0] accWay = '0;
  logic       accEn = 1'b0;
  logic       invEn = 1'b0;
  logic [7:0] validBits = 8'hFF;
  logic       victimReq = 1'b0;
  logic [2:0] victimWay;
  logic       victimFree;

  int numChecks = 0;
  int numFail = 0;

  int         mAge [NS][NW];
  logic [7:0] mBits [NS];

  always #5 clk = ~clk;

  lru_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_lru_victim_sel (
    .clk(clk), .rstN(rstN), .policySel(policySel), .setIdx(setIdx),
    .accWay(accWay), .accEn(accEn), .invEn(invEn), .validBits(validBits),
    .victimReq(victimReq), .victimWay(victimWay), .victimFree(victimFree)
  );

  task automatic checkOut(input string tag, input int expWay, input bit expFree);
    numChecks++;
    if (int'(victimWay) != expWay || victimFree != expFree) begin
      numFail++;
      $display("FAIL %s: way=%0d free=%0d expected way=%0d free=%0d",
               tag, victimWay, victimFree, expWay, expFree);
    end
  endtask

  // Reference update per R6..R9.
  task automatic modelStep(input int s, input int w, input bit acc, input bit inv);
    int old;
    logic [7:0] t;
    old = mAge[s][w];
    if (inv) begin
      for (int v = 0; v < NW; v++) begin
        if (v == w) mAge[s][v] = NW - 1;
        else if (mAge[s][v] > old) mAge[s][v]--;
      end
      mBits[s][w] = 1'b0;
    end else if (acc) begin
      for (int v = 0; v < NW; v++) begin
        if (v == w) mAge[s][v] = 0;
        else if (mAge[s][v] < old) mAge[s][v]++;
      end
      t = mBits[s] | (8'd1 << w);
      mBits[s] = (t == 8'hFF) ? (8'd1 << w) : t;
    end
  endtask

  task automatic modelVictim(input int s, input bit pol, input logic [7:0] vb,
                             input bit req, output int w, output bit free);
    w = 0;
    free = 1'b0;
    if (!req) return;
    if (vb != 8'hFF) begin
      for (int v = NW - 1; v >= 0; v--) if (!vb[v]) w = v;
      free = 1'b1;
    end else if (pol) begin
      for (int v = NW - 1; v >= 0; v--) if (!mBits[s][v]) w = v;
    end else begin
      for (int v = 0; v < NW; v++) if (mAge[s][v] == NW - 1) w = v;
    end
  endtask

  task automatic step(input int s, input int w, input bit acc, input bit inv);
    @(negedge clk);
    setIdx = 2'(s); accWay = 3'(w); accEn = acc; invEn = inv; victimReq = 1'b0;
    #1;
    modelStep(s, w, acc, inv);
  endtask

  task automatic probe(input string tag, input int s, input bit pol,
                       input logic [7:0] vb, input bit req,
                       input int expWay, input bit expFree);
    @(negedge clk);
    setIdx = 2'(s); policySel = pol; validBits = vb; victimReq = req;
    accEn = 1'b0; invEn = 1'b0;
    #1;
    checkOut(tag, expWay, expFree);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    numChecks++;
    numFail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
    $finish;
  end

  initial begin
    int   s, w, expW;
    bit   acc, inv, pol, req, expF;
    logic [7:0] vb;
    string tag;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin
      for (int j = 0; j < NW; j++) mAge[i][j] = j;
      mBits[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state (R5) and request gating (R4)
    probe("R4 idle", 0, 0, 8'hFF, 0, 0, 0);
    probe("R5 reset ages", 0, 0, 8'hFF, 1, 7, 0);
    probe("R5 reset bits", 0, 1, 8'hFF, 1, 0, 0);
    probe("R3 invalid lru", 0, 0, 8'b1110_1011, 1, 2, 1);
    probe("R3 invalid bit", 0, 1, 8'b1110_1011, 1, 2, 1);

    step(0, 7, 1, 0);
    probe("R6 touched way younger", 0, 0, 8'hFF, 1, 6, 0);
    probe("R10 bit history kept", 0, 1, 8'hFF, 1, 0, 0);
    for (int k = 0; k < 6; k++) step(0, k, 1, 0);
    probe("R7 lowest clear bit", 0, 1, 8'hFF, 1, 6, 0);
    step(0, 6, 1, 0);
    probe("R7 all ones wrap", 0, 1, 8'hFF, 1, 0, 0);
    probe("R1 oldest way", 0, 0, 8'hFF, 1, 7, 0);
    probe("R12 request leaves state", 0, 0, 8'hFF, 1, 7, 0);
    step(0, 0, 1, 0);
    probe("R7 bit set on access", 0, 1, 8'hFF, 1, 1, 0);
    step(0, 0, 0, 1);
    probe("R8 invalidate clears bit", 0, 1, 8'hFF, 1, 0, 0);
    probe("R8 invalidate oldest", 0, 0, 8'hFF, 1, 0, 0);
    step(0, 5, 1, 1);
    probe("R9 invalidate wins", 0, 0, 8'hFF, 1, 5, 0);
    probe("R11 other set ages", 1, 0, 8'hFF, 1, 7, 0);
    probe("R11 other set bits", 1, 1, 8'hFF, 1, 0, 0);
    probe("R2 one-bit after wins", 0, 1, 8'hFF, 1, 0, 0);

    // Random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      s   = int'($urandom % NS);
      w   = int'($urandom % NW);
      acc = ($urandom % 3) != 0;
      inv = ($urandom % 8) == 0;
      pol = $urandom % 2;
      req = ($urandom % 4) != 0;
      vb  = (($urandom % 4) == 0) ? 8'($urandom) : 8'hFF;
      setIdx = 2'(s); accWay = 3'(w); accEn = acc; invEn = inv;
      policySel = pol; victimReq = req; validBits = vb;
      #1;
      modelVictim(s, pol, vb, req, expW, expF);
      if (!req) tag = "R4 random idle";
      else if (vb != 8'hFF) tag = "R3 random free";
      else if (pol) tag = "R2 random bits";
      else tag = "R1 random ages";
      checkOut(tag, expW, expF);
      modelStep(s, w, acc, inv);
    end

    @(negedge clk);
    accEn = 1'b0; invEn = 1'b0; victimReq = 1'b0;
    $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
    $finish;
  end
endmodule